// File: doc/BRIEF.md
# Four-Decade BCD Event Tally with Wrap Flag

This block keeps a four-digit decimal tally of single-cycle event strobes. The events come from an input conditioner and are already edge-detected. Each decade holds one BCD digit: units, tens, hundreds and thousands. The digits leave the block packed side by side, ready for a display decoder. An event is counted only when the count-enable gate is high. A measurement controller opens that gate for a fixed window when measuring frequency, lets a 10 Hz tick through when measuring time, and holds it open for plain counting.

When the tally passes 9999, every decade returns to zero in the same clock cycle and a sticky wrap flag is raised. That flag warns that the display no longer holds the true total. Counting goes on after the wrap. The flag stays set until a synchronous clear. The block also drives a one-hot decimal-point select that is decoded from the measurement-range code, so the display reads in kHz, in seconds, or as a bare number.

Top module: `decade_tally`

## Requirements
- R1: After reset, every digit is 0 and the wrap flag is low.
- R2: An event seen with the gate high and clear low adds one to the tally, and the new value appears after the next rising clock edge.
- R3: While the gate is low, events change neither the digits nor the wrap flag.
- R4: A decade that steps from 9 returns to 0 and advances the next decade in the same cycle, so 0009, 0099 and 0999 become 0010, 0100 and 1000.
- R5: A counted event at 9999 yields 0000 after one clock edge and sets the wrap flag on that same edge.
- R6: Once set, the wrap flag stays high until a clear, and counting continues from 0000.
- R7: Clear forces all digits to 0 and the wrap flag low after the next edge. An event in the same cycle as clear is discarded. Counting resumes once clear is low.
- R8: `point_o` is one-hot with bit k lighting the point right of decade k (bit 0 = units). Range code 2 (1 s window) gives bit 3. Code 3 (100 ms window) gives bit 2. Codes 1 (seconds) and 4 (10 ms window) give bit 1. Code 0 (plain count) and codes 5 to 7 give no point.
- R9: Each digit only ever holds a value from 0 to 9. Digit k occupies `digits_o[4k+3:4k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear of the tally and the wrap flag |
| gate_i | input | 1 | Count enable |
| event_i | input | 1 | Single-cycle event strobe |
| range_i | input | 3 | Measurement-range code |
| digits_o | output | 16 | Packed BCD digits, units in the low nibble |
| wrap_o | output | 1 | Sticky flag, set when the tally wraps past 9999 |
| point_o | output | 4 | One-hot decimal-point select |

## Verification
The tally is driven with three kinds of input:
- **Bursts of back-to-back events**, which show whether each event counts exactly once.
- **Events with the gate closed**, which separate gating from counting.
- **Long runs that cross 9, 99, 999 and 9999**, which show whether the carry moves correctly between decades, including the full rollover done in one cycle.

After the rollover, further events show that the wrap flag is sticky and that counting continues. A clear raised together with an event shows that clear takes priority. Every range code, including the unused ones, is applied to check the point select.

// File: rtl/tally_pkg.sv
package tally_pkg;
   localparam int BCD_W = 4;
   localparam logic [BCD_W-1:0] BCD_TOP = 4'd9;

   typedef enum logic [2:0] {
      RNG_PLAIN     = 3'd0,
      RNG_SECONDS   = 3'd1,
      RNG_WIN_1S    = 3'd2,
      RNG_WIN_100MS = 3'd3,
      RNG_WIN_10MS  = 3'd4
   } range_e;
endpackage

// File: rtl/bcd_stage.sv
module bcd_stage
   import tally_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             step_i,
   output logic [BCD_W-1:0] q_o,
   output logic             carry_o
);
   logic at_top;
   assign at_top  = (q_o == BCD_TOP);
   assign carry_o = step_i && at_top;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= '0;
      else if (clr_i)  q_o <= '0;
      else if (step_i) q_o <= at_top ? '0 : q_o + 1'b1;
   end

   assert_digit_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      q_o <= BCD_TOP);
   assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !clr_i && q_o != BCD_TOP) |=> (q_o == $past(q_o) + 4'd1));
   assert_digit_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !clr_i && q_o == BCD_TOP) |=> (q_o == '0));
endmodule

// File: rtl/wrap_latch.sv
module wrap_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic set_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     flag_o <= 1'b0;
      else if (clr_i) flag_o <= 1'b0;
      else if (set_i) flag_o <= 1'b1;
   end

   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/point_decode.sv
module point_decode
   import tally_pkg::*;
#(
   parameter int NUM_DECADES = 4
) (
   input  logic [2:0]             range_i,
   output logic [NUM_DECADES-1:0] point_o
);
   always_comb begin
      point_o = '0;
      case (range_i)
         RNG_WIN_1S:    point_o[3] = 1'b1;
         RNG_WIN_100MS: point_o[2] = 1'b1;
         RNG_SECONDS,
         RNG_WIN_10MS:  point_o[1] = 1'b1;
         default:       point_o = '0;
      endcase
   end

   always_comb begin
      assert_point_onehot_R8: assert ($onehot0(point_o));
   end
endmodule

// File: rtl/decade_tally.sv
module decade_tally
   import tally_pkg::*;
#(
   parameter int NUM_DECADES = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear_i,
   input  logic                         gate_i,
   input  logic                         event_i,
   input  logic [2:0]                   range_i,
   output logic [BCD_W*NUM_DECADES-1:0] digits_o,
   output logic                         wrap_o,
   output logic [NUM_DECADES-1:0]       point_o
);
   localparam int DIG_W = BCD_W * NUM_DECADES;

   if (NUM_DECADES < 4) begin : g_bad_width
      $error("decade_tally: NUM_DECADES must be at least 4 for point placement");
   end

   logic                   count_ok;
   logic [NUM_DECADES:0]   step;

   assign count_ok = event_i && gate_i && !clear_i;
   assign step[0]  = count_ok;

   for (genvar k = 0; k < NUM_DECADES; k++) begin : g_decade
      bcd_stage u_stage (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr_i   (clear_i),
         .step_i  (step[k]),
         .q_o     (digits_o[BCD_W*k +: BCD_W]),
         .carry_o (step[k+1])
      );
   end

   wrap_latch u_wrap (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clear_i),
      .set_i  (step[NUM_DECADES]),
      .flag_o (wrap_o)
   );

   point_decode #(.NUM_DECADES(NUM_DECADES)) u_point (
      .range_i (range_i),
      .point_o (point_o)
   );

   assert_gate_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(event_i && gate_i) && !clear_i) |=> ($stable(digits_o) && $stable(wrap_o)));
   assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (digits_o == {DIG_W{1'b0}} && !wrap_o));
   assert_full_roll_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (count_ok && digits_o == {NUM_DECADES{BCD_TOP}}) |=> (digits_o == {DIG_W{1'b0}} && wrap_o));
endmodule

// File: tb/decade_tally_bench.sv
`timescale 1ns/1ps
module decade_tally_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clear_i = 1'b0;
   logic        gate_i = 1'b0;
   logic        event_i = 1'b0;
   logic [2:0]  range_i = 3'd0;
   logic [15:0] digits_o;
   logic        wrap_o;
   logic [3:0]  point_o;

   int checks = 0;
   int errors = 0;
   int exp_cnt = 0;
   bit exp_wrap = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   decade_tally u_decade_tally (
      .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .gate_i(gate_i),
      .event_i(event_i), .range_i(range_i), .digits_o(digits_o),
      .wrap_o(wrap_o), .point_o(point_o));

   function automatic int shown_value();
      int v = 0;
      for (int k = 3; k >= 0; k--) v = v * 10 + int'(digits_o[4*k +: 4]);
      return v;
   endfunction

   task automatic check_val(string req, int act, int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic check_state(string req);
      for (int k = 0; k < 4; k++)
         check_val("R9 digit range", int'(digits_o[4*k +: 4] <= 4'd9), 1);
      check_val(req, shown_value(), exp_cnt % 10000);
      check_val({req, " wrap"}, int'(wrap_o), int'(exp_wrap));
   endtask

   task automatic pulse_events(int n, bit g);
      @(negedge clk);
      event_i = 1'b1; gate_i = g;
      repeat (n) @(negedge clk);
      event_i = 1'b0; gate_i = 1'b0;
      if (g) begin
         if (exp_cnt + n >= 10000) exp_wrap = 1'b1;
         exp_cnt = exp_cnt + n;
      end
   endtask

   task automatic t_reset();
      check_state("R1 reset");
   endtask

   task automatic t_steps();
      pulse_events(1, 1'b1); check_state("R2 single event");
      pulse_events(3, 1'b1); check_state("R2 burst");
   endtask

   task automatic t_gate_closed();
      pulse_events(7, 1'b0); check_state("R3 gate low");
   endtask

   task automatic t_carries();
      pulse_events(9 - exp_cnt, 1'b1); check_state("R4 at 9");
      pulse_events(1, 1'b1); check_state("R4 0010");
      pulse_events(89, 1'b1); check_state("R4 at 99");
      pulse_events(1, 1'b1); check_state("R4 0100");
      pulse_events(899, 1'b1); check_state("R4 at 999");
      pulse_events(1, 1'b1); check_state("R4 1000");
   endtask

   task automatic t_rollover();
      pulse_events(8999, 1'b1); check_state("R5 at 9999");
      pulse_events(1, 1'b1); check_state("R5 rollover");
      pulse_events(5, 1'b1); check_state("R6 count after wrap");
      pulse_events(4, 1'b0); check_state("R6 sticky, gate low");
   endtask

   task automatic t_clear();
      @(negedge clk);
      clear_i = 1'b1; event_i = 1'b1; gate_i = 1'b1;
      @(negedge clk);
      clear_i = 1'b0; event_i = 1'b0; gate_i = 1'b0;
      exp_cnt = 0; exp_wrap = 1'b0;
      check_state("R7 clear with event");
      pulse_events(2, 1'b1); check_state("R7 resume after clear");
   endtask

   task automatic t_points();
      logic [3:0] want [8] = '{4'b0000, 4'b0010, 4'b1000, 4'b0100,
                               4'b0010, 4'b0000, 4'b0000, 4'b0000};
      for (int c = 0; c < 8; c++) begin
         range_i = 3'(c);
         #1;
         check_val($sformatf("R8 point code %0d", c), int'(point_o), int'(want[c]));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_steps();
      t_gate_closed();
      t_carries();
      t_rollover();
      t_clear();
      t_points();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule